// File: doc/BRIEF.md
# Debug Port Protocol Switching Sequence Generator

This block emits, one bit at a time, the fixed line patterns that a debug probe sends to a combined serial-wire/JTAG debug port. These patterns reset the serial-wire link, move the port between serial-wire and JTAG operation, or put it into and bring it out of a dormant state. A pulse on `start` latches a 3-bit command. The block then produces a divided line clock and the TMS/SWDIO data level. Bits go out least-significant bit of each byte first, with the bytes in stream order. A one-cycle `done` pulse follows the last bit.

Each pattern is made of segments: long runs of high cycles, 16-bit switch codes, a 128-bit selection alert, activation codes and trailing idle cycles. The block computes the level of the current bit from the latched command and a bit index. It stores no pattern memory and does not handle read/write transactions.

Top module: `swjSeqGen`

## Requirements
- R1: After reset, `lineClk` is 0, `dataOut` is 1, and `dataOe`, `busy` and `done` are 0.
- R2: `start` with `cmd` 0..6 runs these patterns and bit counts: 0 line reset (64), 1 JTAG-to-SWD (136), 2 SWD-to-JTAG (80), 3 SWD-to-dormant (72), 4 dormant-to-SWD (224), 5 JTAG-to-dormant (40), 6 dormant-to-JTAG (160).
- R3: Line reset is 56 high bits followed by 8 low bits.
- R4: JTAG-to-SWD is 56 high bits, code 0xE79E, 56 high bits and 8 low bits. SWD-to-JTAG is 56 high bits, code 0xE73C and 8 high bits. SWD-to-dormant is 56 high bits and code 0xE3BC. Each code is sent bit 0 first.
- R5: Both dormant exits start with 8 high bits, then the 128-bit selection alert (byte stream 0x92 F3 09 62 95 2D 85 86 E9 AF DD E3 A2 0E BC 19, each byte LSB first), then 4 low bits. Dormant-to-SWD continues with activation code 0x1A, 68 high bits and 8 low bits. Dormant-to-JTAG continues with 20 low bits.
- R6: JTAG-to-dormant is 9 high bits followed by the 31 low-order-first bits of the byte stream 0xBA 0xBB 0xBB 0x33.
- R7: Each bit lasts 2*HALF_CYCLES clock cycles: `lineClk` is low for the first half and high for the second. `dataOut` changes only while `lineClk` is low. `busy` is high for exactly 2*HALF_CYCLES times the bit count.
- R8: `start` while `busy` is ignored; the running pattern completes unchanged.
- R9: `done` is high for exactly one cycle, in the first cycle in which `busy` is low after a pattern.
- R10: `dataOe` is high exactly while `busy` is high. When idle, `lineClk` is low and `dataOut` holds the last bit sent.
- R11: `start` with `cmd` 7 is ignored; the block stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to emit the pattern selected by cmd |
| cmd | input | 3 | Pattern select, 0..6 |
| lineClk | output | 1 | Divided debug line clock |
| dataOut | output | 1 | TMS/SWDIO data level |
| dataOe | output | 1 | Output enable for the data line |
| busy | output | 1 | Pattern in progress |
| done | output | 1 | One-cycle end-of-pattern pulse |

## Verification
The assertions check the following on every cycle:
- the data level never changes while the line clock is high;
- the output enable tracks `busy`, and the clock stays low when idle;
- `done` is a single pulse that follows `busy` falling;
- the latched command stays fixed for the whole run.

Only the bench scenarios can show that each of the seven patterns has the right bits in the right order and the right length. The bench compares every captured bit against its own byte-stream model. Its scenarios also show that a second start mid-run or a command of 7 leaves the output unchanged.

// File: rtl/swjSeqPkg.sv
package swjSeqPkg;

  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    CMD_LINE_RESET   = 3'd0,
    CMD_JTAG_TO_SWD  = 3'd1,
    CMD_SWD_TO_JTAG  = 3'd2,
    CMD_SWD_TO_DORM  = 3'd3,
    CMD_DORM_TO_SWD  = 3'd4,
    CMD_JTAG_TO_DORM = 3'd5,
    CMD_DORM_TO_JTAG = 3'd6
  } swjCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic rise;
    logic step;
    logic finish;
  } seqStrobe_t;

  localparam logic [127:0] ALERT_CODE = 128'h19BC0EA2E3DDAFE986852D956209F392;
  localparam logic [15:0]  TO_SWD_CODE  = 16'hE79E;
  localparam logic [15:0]  TO_JTAG_CODE = 16'hE73C;
  localparam logic [15:0]  TO_DORM_CODE = 16'hE3BC;
  localparam logic [7:0]   SWD_ACT_CODE = 8'h1A;
  localparam logic [63:0]  JTAG_DORM_SEQ = 64'h00000067777775FF;

  function automatic logic [IDX_W-1:0] seqLen(input logic [2:0] c);
    case (c)
      CMD_LINE_RESET:   return 8'd64;
      CMD_JTAG_TO_SWD:  return 8'd136;
      CMD_SWD_TO_JTAG:  return 8'd80;
      CMD_SWD_TO_DORM:  return 8'd72;
      CMD_DORM_TO_SWD:  return 8'd224;
      CMD_JTAG_TO_DORM: return 8'd40;
      CMD_DORM_TO_JTAG: return 8'd160;
      default:          return 8'd1;
    endcase
  endfunction

  // level of bit i of pattern c
  function automatic logic seqBit(input logic [2:0] c, input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] codeOff;
    logic [IDX_W-1:0] alertOff;
    logic [IDX_W-1:0] actOff;
    codeOff  = i - 8'd56;
    alertOff = i - 8'd8;
    actOff   = i - 8'd140;
    case (c)
      CMD_LINE_RESET:  return i < 8'd56;
      CMD_JTAG_TO_SWD: begin
        if (i < 8'd56)      return 1'b1;
        else if (i < 8'd72) return TO_SWD_CODE[codeOff[3:0]];
        else                return i < 8'd128;
      end
      CMD_SWD_TO_JTAG: begin
        if (i < 8'd56)      return 1'b1;
        else if (i < 8'd72) return TO_JTAG_CODE[codeOff[3:0]];
        else                return 1'b1;
      end
      CMD_SWD_TO_DORM: begin
        if (i < 8'd56)      return 1'b1;
        else                return TO_DORM_CODE[codeOff[3:0]];
      end
      CMD_DORM_TO_SWD: begin
        if (i < 8'd8)        return 1'b1;
        else if (i < 8'd136) return ALERT_CODE[alertOff[6:0]];
        else if (i < 8'd140) return 1'b0;
        else if (i < 8'd148) return SWD_ACT_CODE[actOff[2:0]];
        else                 return i < 8'd216;
      end
      CMD_JTAG_TO_DORM: return JTAG_DORM_SEQ[i[5:0]];
      CMD_DORM_TO_JTAG: begin
        if (i < 8'd8)        return 1'b1;
        else if (i < 8'd136) return ALERT_CODE[alertOff[6:0]];
        else                 return 1'b0;
      end
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/swjSeqCtrl.sv
module swjSeqCtrl
  import swjSeqPkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] cmd,
  input  logic       lastBit,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int PH_CNT = 2 * HALF_CYCLES;
  localparam int PH_W = (PH_CNT > 2) ? $clog2(PH_CNT) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF_CYCLES - 1);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(PH_CNT - 1);

  typedef enum logic {ST_IDLE, ST_SHIFT} ctrlState_e;

  ctrlState_e stateQ;
  logic [PH_W-1:0] phaseQ;
  logic doneQ;
  logic cmdValid;
  logic bitEnd;

  assign cmdValid = (cmd <= 3'd6);
  assign bitEnd   = (stateQ == ST_SHIFT) && (phaseQ == PH_END);

  always_comb begin
    strobe        = '0;
    strobe.load   = (stateQ == ST_IDLE) && start && cmdValid;
    strobe.rise   = (stateQ == ST_SHIFT) && (phaseQ == PH_RISE);
    strobe.step   = bitEnd && !lastBit;
    strobe.finish = bitEnd && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.finish;
      if (strobe.load) begin
        stateQ <= ST_SHIFT;
        phaseQ <= '0;
      end else if (stateQ == ST_SHIFT) begin
        if (phaseQ == PH_END) phaseQ <= '0;
        else                  phaseQ <= phaseQ + 1'b1;
        if (strobe.finish)    stateQ <= ST_IDLE;
      end
    end
  end

  assign busy = (stateQ == ST_SHIFT);
  assign done = doneQ;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/swjSeqData.sv
module swjSeqData
  import swjSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic [2:0] cmd,
  output logic       lineClk,
  output logic       dataOut,
  output logic       dataOe,
  output logic       lastBit
);

  logic [2:0]       cmdQ;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] idxNext;
  logic             clkQ;
  logic             dataQ;
  logic             oeQ;

  assign idxNext = idxQ + 1'b1;
  assign lastBit = (idxQ == seqLen(cmdQ) - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= '0;
      idxQ  <= '0;
      clkQ  <= 1'b0;
      dataQ <= 1'b1;
      oeQ   <= 1'b0;
    end else if (strobe.load) begin
      cmdQ  <= cmd;
      idxQ  <= '0;
      clkQ  <= 1'b0;
      dataQ <= seqBit(cmd, '0);
      oeQ   <= 1'b1;
    end else if (strobe.rise) begin
      clkQ <= 1'b1;
    end else if (strobe.step) begin
      clkQ  <= 1'b0;
      idxQ  <= idxNext;
      dataQ <= seqBit(cmdQ, idxNext);
    end else if (strobe.finish) begin
      clkQ <= 1'b0;
      oeQ  <= 1'b0;
    end
  end

  assign lineClk = clkQ;
  assign dataOut = dataQ;
  assign dataOe  = oeQ;

  p_data_change_clk_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataQ) |-> !clkQ);

  p_clk_needs_oe_r10: assert property (@(posedge clk) disable iff (!rstN)
    clkQ |-> oeQ);

  p_cmd_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (oeQ && !strobe.finish) |=> $stable(cmdQ));

endmodule

// File: rtl/swjSeqGen.sv
module swjSeqGen
  import swjSeqPkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] cmd,
  output logic       lineClk,
  output logic       dataOut,
  output logic       dataOe,
  output logic       busy,
  output logic       done
);

  seqStrobe_t strobe;
  logic lastBit;

  swjSeqCtrl #(.HALF_CYCLES(HALF_CYCLES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cmd     (cmd),
    .lastBit (lastBit),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  swjSeqData i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmd     (cmd),
    .lineClk (lineClk),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .lastBit (lastBit)
  );

  p_oe_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    dataOe == busy);

  p_clk_idle_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineClk);

endmodule

// File: tb/test_swjSeqGen.sv
module test_swjSeqGen;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic lineClk, dataOut, dataOe, busy, done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swjSeqGen #(.HALF_CYCLES(HALF)) i_swjSeqGen (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd),
    .lineClk(lineClk), .dataOut(dataOut), .dataOe(dataOe),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] alertByte(int k);
    case (k)
      0: return 8'h92;  1: return 8'hF3;  2: return 8'h09;  3: return 8'h62;
      4: return 8'h95;  5: return 8'h2D;  6: return 8'h85;  7: return 8'h86;
      8: return 8'hE9;  9: return 8'hAF; 10: return 8'hDD; 11: return 8'hE3;
      12: return 8'hA2; 13: return 8'h0E; 14: return 8'hBC; default: return 8'h19;
    endcase
  endfunction

  // model of each pattern as a byte stream
  function automatic logic [7:0] seqByte(int c, int k);
    case (c)
      0: return (k < 7) ? 8'hFF : 8'h00;
      1: begin
        if (k < 7) return 8'hFF;
        if (k == 7) return 8'h9E;
        if (k == 8) return 8'hE7;
        return (k < 16) ? 8'hFF : 8'h00;
      end
      2: begin
        if (k == 7) return 8'h3C;
        if (k == 8) return 8'hE7;
        return 8'hFF;
      end
      3: begin
        if (k == 7) return 8'hBC;
        if (k == 8) return 8'hE3;
        return 8'hFF;
      end
      4: begin
        if (k == 0) return 8'hFF;
        if (k <= 16) return alertByte(k - 1);
        if (k == 17) return 8'hA0;
        if (k == 18) return 8'hF1;
        return (k < 27) ? 8'hFF : 8'h00;
      end
      5: begin
        case (k)
          0: return 8'hFF; 1: return 8'h75; 2: return 8'h77;
          3: return 8'h77; default: return 8'h67;
        endcase
      end
      default: begin
        if (k == 0) return 8'hFF;
        if (k <= 16) return alertByte(k - 1);
        return 8'h00;
      end
    endcase
  endfunction

  function automatic int modelLen(int c);
    case (c)
      0: return 64;  1: return 136; 2: return 80; 3: return 72;
      4: return 224; 5: return 40;  default: return 160;
    endcase
  endfunction

  function automatic logic modelBit(int c, int i);
    logic [7:0] b;
    b = seqByte(c, i / 8);
    return b[i % 8];
  endfunction

  function automatic string patReq(int c);
    case (c)
      0: return "R3";
      1, 2, 3: return "R4";
      4, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runSeq(input int c, input bit interrupt, input int other);
    int busyCyc = 0;
    int bits = 0;
    int mism = 0;
    int oeBad = 0;
    int highChange = 0;
    int guard = 0;
    bit seenDone = 0;
    logic doneBusy = 1'b0;
    logic prevClk = 1'b0;
    logic prevData = 1'b0;
    logic lastLevel;
    int len;
    len = modelLen(c);
    lastLevel = modelBit(c, len - 1);
    @(negedge clk);
    start = 1'b1;
    cmd = 3'(c);
    @(negedge clk);
    start = 1'b0;
    while (!seenDone && guard < 5000) begin
      if (busy) busyCyc++;
      if (busy && !dataOe) oeBad++;
      if (prevClk && lineClk && dataOut != prevData) highChange++;
      if (lineClk && !prevClk) begin
        if (dataOut !== modelBit(c, bits)) mism++;
        bits++;
      end
      prevClk = lineClk;
      prevData = dataOut;
      if (done) begin
        seenDone = 1;
        doneBusy = busy;
      end
      if (interrupt && guard == 10) begin
        start = 1'b1;
        cmd = 3'(other);
      end
      if (interrupt && guard == 11) start = 1'b0;
      @(negedge clk);
      guard++;
    end
    check(bits == len, "R2 bit count", bits, len);
    check(mism == 0, interrupt ? "R8 pattern after mid-run start" : patReq(c), mism, 0);
    check(busyCyc == 2 * HALF * len, "R7 busy duration", busyCyc, 2 * HALF * len);
    check(highChange == 0, "R7 data change while clock high", highChange, 0);
    check(oeBad == 0, "R10 oe during busy", oeBad, 0);
    check(seenDone && !doneBusy, "R9 done with busy low", int'(seenDone), 1);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(!busy && !dataOe && !lineClk, "R10 idle oe and clock",
          int'({busy, dataOe, lineClk}), 0);
    check(dataOut == lastLevel, "R10 idle level holds last bit",
          int'(dataOut), int'(lastLevel));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(lineClk == 1'b0 && dataOut == 1'b1 && !dataOe && !busy && !done,
          "R1 reset outputs", int'({lineClk, dataOut, dataOe, busy, done}), 8);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !dataOe, "R1 idle after reset", int'({busy, dataOe}), 0);

    // R2 directed: every command once
    for (int c = 0; c < 7; c++) runSeq(c, 1'b0, 0);

    // R8 directed: start mid-run with another command
    runSeq(5, 1'b1, 4);
    runSeq(0, 1'b1, 6);

    // R11: command 7 ignored
    @(negedge clk);
    start = 1'b1;
    cmd = 3'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(!busy && !lineClk && !dataOe && !done, "R11 code 7 ignored",
            int'({busy, lineClk, dataOe, done}), 0);
    end

    // random mix
    for (int n = 0; n < 30; n++) begin
      int c;
      int o;
      bit intr;
      c = int'($urandom % 7);
      o = int'($urandom % 8);
      intr = ($urandom % 3) == 0;
      runSeq(c, intr, o);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule